// File: doc/BRIEF.md
# Doorbell Mailbox with Message Registers

This block is a one-way mailbox between two processors on the same chip. The sender (side A) stores a message of up to thirty-two 32-bit words in a bank of message registers. It then writes a trigger register to ring a doorbell. The receiver (side B) is interrupted and reads the words back. Word 0 carries the byte length in its low 7 bits, so the receiver reads ceil(length/4) words. Side B then writes the same trigger register with the acknowledge bit, and that interrupts side A.

Each side reaches the same register space through its own word-wide register port. Both ports can access the space in the same cycle, and a fixed priority settles a write collision. One common status register records the doorbell and acknowledge events, and a write-one-to-clear register clears them. Each side has its own enable register, which masks the common status onto that side's interrupt line.

Register map (byte offsets; bits 1:0 of the address are ignored): message words at 0x00 to 0x7C, trigger at 0x80, side-A enable at 0xBC, side-B enable at 0xC0, clear at 0xC4, status at 0xC8. Status and enable bit 0 is the doorbell event and bit 1 is the acknowledge event.

Top module: `mbx_doorbell_mailbox`

## Requirements
- R1: The 32 message words at 0x00 to 0x7C reset to zero. A word written from either port reads back unchanged from both ports.
- R2: When both ports write the same writable register in the same cycle, the value from port A is kept.
- R3: A write to 0x80 with bit 0 set sets status bit 0 (doorbell), and one with bit 1 set sets status bit 1 (acknowledge). Both take effect at the write's clock edge. Bits 31:2 of that write have no effect.
- R4: The trigger register at 0x80 always reads as zero.
- R5: Writing a 1 to a bit of the clear register at 0xC4 clears that status bit, and writing a 0 leaves it unchanged. 0xC4 reads as zero.
- R6: If a status bit is set and cleared in the same cycle, from either port or both, it ends up set.
- R7: The status register at 0xC8 is read-only. Writes to it leave the status unchanged.
- R8: The side-A enable register (0xBC) and the side-B enable register (0xC0) each store data bits 1:0 of a write and read them back zero-extended.
- R9: irq_a is high exactly when some status bit is set and enabled in the side-A enable register. irq_b is the same with the side-B enable register. Both follow their registers with no added delay.
- R10: A read returns data on the port's rdata one cycle after the request, with rvalid high in that cycle. Unmapped offsets read as zero.
- R11: After reset the status register and both enable registers are zero, and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 8 | Port A byte address |
| a_wdata | input | 32 | Port A write data |
| a_rdata | output | 32 | Port A read data |
| a_rvalid | output | 1 | Port A read data valid |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 8 | Port B byte address |
| b_wdata | input | 32 | Port B write data |
| b_rdata | output | 32 | Port B read data |
| b_rvalid | output | 1 | Port B read data valid |
| irq_a | output | 1 | Interrupt to side A |
| irq_b | output | 1 | Interrupt to side B |

## Verification
The assertions assume that a port's write data is meaningful only in cycles where that port's en and we are both high. They also assume that addresses are compared only on their word part, and that a read and a write to the same register from the two ports in one cycle are not expected to forward the new value. The stimulus drives every access for exactly one cycle and returns en to low between accesses. It uses simultaneous accesses from both ports only for deliberate write collisions: a message word, an enable register, and a set of a status bit against a clear of the same bit. It never reads a register in the cycle another port writes it.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int unsigned TRIG_OFS = 32'h80;
   localparam int unsigned ENA_OFS  = 32'hBC;
   localparam int unsigned ENB_OFS  = 32'hC0;
   localparam int unsigned CLR_OFS  = 32'hC4;
   localparam int unsigned STAT_OFS = 32'hC8;

   localparam int unsigned STAT_W  = 2;
   localparam int unsigned DB_BIT  = 0;
   localparam int unsigned ACK_BIT = 1;

   typedef enum logic [2:0] {
      RK_ZERO,
      RK_MSG,
      RK_ENA,
      RK_ENB,
      RK_STAT
   } rd_kind_e;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
   parameter int ADDR_W    = 8,
   parameter int MSG_WORDS = 32,
   parameter int IDX_W     = $clog2(MSG_WORDS)
) (
   input  logic                 en,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 msg_we,
   output logic                 trig_we,
   output logic                 clr_we,
   output logic                 ena_we,
   output logic                 enb_we,
   output logic                 rd_req,
   output mbx_pkg::rd_kind_e    rd_kind,
   output logic [IDX_W-1:0]     word_idx
);
   import mbx_pkg::*;

   localparam logic [ADDR_W-1:0] MSG_END = ADDR_W'(MSG_WORDS * 4);

   logic [ADDR_W-1:0] addr_w;
   logic              hit_msg, hit_trig, hit_clr, hit_ena, hit_enb, hit_stat;

   assign addr_w   = {addr[ADDR_W-1:2], 2'b00};
   assign word_idx = addr[IDX_W+1:2];

   assign hit_msg  = addr_w < MSG_END;
   assign hit_trig = addr_w == ADDR_W'(TRIG_OFS);
   assign hit_clr  = addr_w == ADDR_W'(CLR_OFS);
   assign hit_ena  = addr_w == ADDR_W'(ENA_OFS);
   assign hit_enb  = addr_w == ADDR_W'(ENB_OFS);
   assign hit_stat = addr_w == ADDR_W'(STAT_OFS);

   assign msg_we  = en & we & hit_msg;
   assign trig_we = en & we & hit_trig;
   assign clr_we  = en & we & hit_clr;
   assign ena_we  = en & we & hit_ena;
   assign enb_we  = en & we & hit_enb;
   assign rd_req  = en & ~we;

   always_comb begin
      rd_kind = RK_ZERO;
      if (hit_msg)       rd_kind = RK_MSG;
      else if (hit_ena)  rd_kind = RK_ENA;
      else if (hit_enb)  rd_kind = RK_ENB;
      else if (hit_stat) rd_kind = RK_STAT;
   end
endmodule

// File: rtl/mbx_msg_bank.sv
module mbx_msg_bank #(
   parameter int DATA_W    = 32,
   parameter int MSG_WORDS = 32,
   parameter int IDX_W     = $clog2(MSG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [IDX_W-1:0]  a_idx,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              b_we,
   input  logic [IDX_W-1:0]  b_idx,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic [IDX_W-1:0]  a_ridx,
   input  logic [IDX_W-1:0]  b_ridx,
   output logic [DATA_W-1:0] a_rword,
   output logic [DATA_W-1:0] b_rword
);
   logic [DATA_W-1:0] words [MSG_WORDS];

   for (genvar w = 0; w < MSG_WORDS; w++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (a_we && a_idx == IDX_W'(w))
            q <= a_wdata;
         else if (b_we && b_idx == IDX_W'(w))
            q <= b_wdata;
      end
      assign words[w] = q;
   end

   assign a_rword = words[a_ridx];
   assign b_rword = words[b_ridx];

   AST_MSG_PORT_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we && b_we && a_idx == b_idx) |=> words[$past(a_idx)] == $past(a_wdata)); // R2

   AST_MSG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (b_we && !a_we) |=> words[$past(b_idx)] == $past(b_wdata)); // R1
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl #(
   parameter int DATA_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        a_trig,
   input  logic                        a_clr,
   input  logic                        a_ena,
   input  logic                        a_enb,
   input  logic [DATA_W-1:0]           a_wdata,
   input  logic                        b_trig,
   input  logic                        b_clr,
   input  logic                        b_ena,
   input  logic                        b_enb,
   input  logic [DATA_W-1:0]           b_wdata,
   output logic [mbx_pkg::STAT_W-1:0]  status,
   output logic [mbx_pkg::STAT_W-1:0]  en_a,
   output logic [mbx_pkg::STAT_W-1:0]  en_b,
   output logic                        irq_a,
   output logic                        irq_b
);
   import mbx_pkg::*;

   logic [STAT_W-1:0] set_v, clr_v;

   assign set_v = (a_trig ? a_wdata[STAT_W-1:0] : '0) | (b_trig ? b_wdata[STAT_W-1:0] : '0);
   assign clr_v = (a_clr  ? a_wdata[STAT_W-1:0] : '0) | (b_clr  ? b_wdata[STAT_W-1:0] : '0);

   for (genvar i = 0; i < STAT_W; i++) begin : g_stat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        status[i] <= 1'b0;
         else if (set_v[i]) status[i] <= 1'b1;
         else if (clr_v[i]) status[i] <= 1'b0;
      end

      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (a_trig && a_wdata[i] && b_clr && b_wdata[i]) |=> status[i]); // R6

      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
         (b_clr && b_wdata[i] && !a_trig && !b_trig) |=> !status[i]); // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a <= '0;
         en_b <= '0;
      end else begin
         if (a_ena)      en_a <= a_wdata[STAT_W-1:0];
         else if (b_ena) en_a <= b_wdata[STAT_W-1:0];
         if (a_enb)      en_b <= a_wdata[STAT_W-1:0];
         else if (b_enb) en_b <= b_wdata[STAT_W-1:0];
      end
   end

   assign irq_a = |(status & en_a);
   assign irq_b = |(status & en_b);

   AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_trig && !b_trig && !a_clr && !b_clr) |=> $stable(status)); // R7

   AST_ENA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      a_ena |=> en_a == $past(a_wdata[STAT_W-1:0])); // R8

   AST_IRQ_A_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a == '0) |-> !irq_a); // R9

   AST_IRQ_B_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_b == '0) |-> !irq_b); // R9
endmodule

// File: rtl/mbx_doorbell_mailbox.sv
module mbx_doorbell_mailbox #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int MSG_WORDS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic              a_rvalid,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              b_rvalid,
   output logic              irq_a,
   output logic              irq_b
);
   import mbx_pkg::*;

   localparam int IDX_W = $clog2(MSG_WORDS);

   if (MSG_WORDS * 4 > int'(TRIG_OFS)) begin : g_bad_depth
      $error("message bank overlaps the trigger register");
   end
   if (DATA_W < int'(STAT_W)) begin : g_bad_width
      $error("data width too narrow for status bits");
   end
   if (ADDR_W < IDX_W + 2 || (1 << ADDR_W) <= int'(STAT_OFS)) begin : g_bad_addr
      $error("address width cannot reach the register map");
   end

   logic              a_msg_we, a_trig, a_clr, a_ena, a_enb, a_rd;
   logic              b_msg_we, b_trig, b_clr, b_ena, b_enb, b_rd;
   rd_kind_e          a_kind, b_kind;
   logic [IDX_W-1:0]  a_idx, b_idx;
   logic [DATA_W-1:0] a_word, b_word;
   logic [STAT_W-1:0] status, en_a, en_b;

   mbx_port_dec #(.ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_dec_a (
      .en(a_en), .we(a_we), .addr(a_addr),
      .msg_we(a_msg_we), .trig_we(a_trig), .clr_we(a_clr),
      .ena_we(a_ena), .enb_we(a_enb), .rd_req(a_rd),
      .rd_kind(a_kind), .word_idx(a_idx)
   );

   mbx_port_dec #(.ADDR_W(ADDR_W), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_dec_b (
      .en(b_en), .we(b_we), .addr(b_addr),
      .msg_we(b_msg_we), .trig_we(b_trig), .clr_we(b_clr),
      .ena_we(b_ena), .enb_we(b_enb), .rd_req(b_rd),
      .rd_kind(b_kind), .word_idx(b_idx)
   );

   mbx_msg_bank #(.DATA_W(DATA_W), .MSG_WORDS(MSG_WORDS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_msg_we), .a_idx(a_idx), .a_wdata(a_wdata),
      .b_we(b_msg_we), .b_idx(b_idx), .b_wdata(b_wdata),
      .a_ridx(a_idx), .b_ridx(b_idx),
      .a_rword(a_word), .b_rword(b_word)
   );

   mbx_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .a_trig(a_trig), .a_clr(a_clr), .a_ena(a_ena), .a_enb(a_enb), .a_wdata(a_wdata),
      .b_trig(b_trig), .b_clr(b_clr), .b_ena(b_ena), .b_enb(b_enb), .b_wdata(b_wdata),
      .status(status), .en_a(en_a), .en_b(en_b),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   function automatic logic [DATA_W-1:0] pick(input rd_kind_e k, input logic [DATA_W-1:0] w,
                                              input logic [STAT_W-1:0] ea, input logic [STAT_W-1:0] eb,
                                              input logic [STAT_W-1:0] st);
      case (k)
         RK_MSG:  return w;
         RK_ENA:  return DATA_W'(ea);
         RK_ENB:  return DATA_W'(eb);
         RK_STAT: return DATA_W'(st);
         default: return '0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata  <= '0;
         b_rdata  <= '0;
         a_rvalid <= 1'b0;
         b_rvalid <= 1'b0;
      end else begin
         a_rvalid <= a_rd;
         b_rvalid <= b_rd;
         if (a_rd) a_rdata <= pick(a_kind, a_word, en_a, en_b, status);
         if (b_rd) b_rdata <= pick(b_kind, b_word, en_a, en_b, status);
      end
   end

   AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && !a_we && {a_addr[ADDR_W-1:2], 2'b00} == ADDR_W'(TRIG_OFS)) |=> a_rdata == '0); // R4

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && !b_we) |=> b_rvalid); // R10

   AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_en && !a_we) |=> !a_rvalid); // R10
endmodule

// File: tb/mbx_doorbell_mailbox_test.sv
module mbx_doorbell_mailbox_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] TRIG = 8'h80, ENA = 8'hBC, ENB = 8'hC0, CLR = 8'hC4, STAT = 8'hC8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
   logic [7:0]  a_addr = 0, b_addr = 0;
   logic [31:0] a_wdata = 0, b_wdata = 0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_rvalid, b_rvalid, irq_a, irq_b;

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   logic [31:0] qa_d[$], qb_d[$];
   string       qa_t[$], qb_t[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mbx_doorbell_mailbox uut (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_rvalid(a_rvalid),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_rvalid(b_rvalid),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle();
      a_en = 0; a_we = 0; b_en = 0; b_we = 0;
   endtask

   task automatic wr(input int port, input logic [7:0] ad, input logic [31:0] d);
      @(negedge clk);
      if (port == 0) begin a_en = 1; a_we = 1; a_addr = ad; a_wdata = d; end
      else           begin b_en = 1; b_we = 1; b_addr = ad; b_wdata = d; end
      @(negedge clk);
      idle();
   endtask

   task automatic wr2(input logic [7:0] ada, input logic [31:0] da,
                      input logic [7:0] adb, input logic [31:0] db);
      @(negedge clk);
      a_en = 1; a_we = 1; a_addr = ada; a_wdata = da;
      b_en = 1; b_we = 1; b_addr = adb; b_wdata = db;
      @(negedge clk);
      idle();
   endtask

   // driver: issue a read and push its expected value to the scoreboard
   task automatic rd(input int port, input logic [7:0] ad, input logic [31:0] exp, input string tag);
      @(negedge clk);
      if (port == 0) begin a_en = 1; a_we = 0; a_addr = ad; qa_d.push_back(exp); qa_t.push_back(tag); end
      else           begin b_en = 1; b_we = 0; b_addr = ad; qb_d.push_back(exp); qb_t.push_back(tag); end
      @(negedge clk);
      idle();
   endtask

   task automatic irqs(input logic ea, input logic eb, input string tag);
      chk({31'b0, irq_a}, {31'b0, ea}, {tag, " irq_a"});
      chk({31'b0, irq_b}, {31'b0, eb}, {tag, " irq_b"});
   endtask

   // monitor: pop and compare as read data comes out
   always @(negedge clk) begin
      if (rst_n && a_rvalid) begin
         if (qa_d.size() == 0) chk(a_rdata, 32'hx, "R10 unexpected rvalid A");
         else chk(a_rdata, qa_d.pop_front(), qa_t.pop_front());
      end
      if (rst_n && b_rvalid) begin
         if (qb_d.size() == 0) chk(b_rdata, 32'hx, "R10 unexpected rvalid B");
         else chk(b_rdata, qb_d.pop_front(), qb_t.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R11 reset state
      irqs(0, 0, "R11 reset");
      rd(0, STAT, 0, "R11 status after reset");
      rd(0, ENA, 0, "R11 enable A after reset");
      rd(1, ENB, 0, "R11 enable B after reset");
      rd(1, 8'h00, 0, "R1 word0 reset");
      rd(0, 8'h7C, 0, "R1 word31 reset");

      // R1 message storage across ports
      for (int i = 0; i < 4; i++) wr(0, 8'(i * 4), 32'hA5A5_0000 + i);
      for (int i = 0; i < 4; i++) rd(1, 8'(i * 4), 32'hA5A5_0000 + i, "R1 A->B word");
      wr(1, 8'h7C, 32'hDEAD_BEEF);
      rd(0, 8'h7C, 32'hDEAD_BEEF, "R1 B->A word31");

      // R8 enables keep bits 1:0
      wr(0, ENA, 32'hFFFF_FFFE);
      rd(0, ENA, 32'h2, "R8 enable A");
      wr(1, ENB, 32'h1);
      rd(1, ENB, 32'h1, "R8 enable B");
      irqs(0, 0, "R9 idle");

      // R3 upper trigger bits do nothing
      wr(0, TRIG, 32'hFFFF_FFFC);
      rd(0, STAT, 0, "R3 upper trigger bits");
      // R3 doorbell
      wr(0, TRIG, 32'h1);
      irqs(0, 1, "R9 doorbell");
      rd(1, STAT, 32'h1, "R3 doorbell status");
      rd(1, TRIG, 0, "R4 trigger reads zero");

      // R5 clear
      wr(1, CLR, 32'h0);
      rd(1, STAT, 32'h1, "R5 clear with zero");
      wr(1, CLR, 32'h1);
      irqs(0, 0, "R5 after clear");
      rd(1, STAT, 0, "R5 cleared");
      rd(0, CLR, 0, "R5 clear reads zero");

      // R3 acknowledge
      wr(1, TRIG, 32'h2);
      irqs(1, 0, "R9 ack");
      rd(0, STAT, 32'h2, "R3 ack status");

      // R7 status read-only
      wr(0, STAT, 32'hFFFF_FFFF);
      rd(0, STAT, 32'h2, "R7 status write ignored");
      wr(0, CLR, 32'h2);
      irqs(0, 0, "R5 ack cleared");

      // R6 set beats clear
      wr2(TRIG, 32'h1, CLR, 32'h1);
      irqs(0, 1, "R6 set vs clear");
      rd(1, STAT, 32'h1, "R6 set wins");
      wr2(CLR, 32'h3, TRIG, 32'h2);
      rd(0, STAT, 32'h2, "R6 mixed set and clear");
      irqs(1, 0, "R9 after mixed");

      // R2 collisions
      wr2(8'h14, 32'h1111_1111, 8'h14, 32'h2222_2222);
      rd(1, 8'h14, 32'h1111_1111, "R2 word collision");
      wr2(ENB, 32'h0, ENB, 32'h3);
      rd(0, ENB, 32'h0, "R2 enable collision");

      // R10 address handling
      rd(0, 8'h0B, 32'hA5A5_0002, "R10 low address bits ignored");
      rd(1, 8'hD0, 0, "R10 unmapped");
      rd(0, 8'hFC, 0, "R10 unmapped top");

      // R9 masking
      wr(0, ENA, 32'h0);
      irqs(0, 0, "R9 masked");

      repeat (3) @(negedge clk);
      chk(32'(qa_d.size() + qb_d.size()), 0, "R10 reads left unanswered");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule